// File: doc/BRIEF.md
# Timer overflow status and interrupt enable register

This block is an 8-bit memory-mapped register that gathers wrap events from three 16-bit timer channels. For each channel it holds a sticky event flag and an interrupt enable bit. It drives one interrupt request line per channel. The timer counters are outside the block. Each counter reports to the block through a one-cycle overflow pulse, and channel 2 also reports through a one-cycle underflow pulse.

Software clears a flag in two steps. It first reads the register while that flag is 1, which arms the flag. It then writes 0 to that bit position. A write of 0 to a flag that is not armed leaves the flag set. The next write to the register uses up the armed state, whatever value it writes. This protects against a clear that would lose an event the software never saw.

The bus is synchronous. It has a chip select, a write enable, 8-bit write data and registered 8-bit read data. The reset is active low and asynchronous.

Top module: `ovf_status_reg`

## Requirements
- R1: After reset, all flags, enables and arms are 0. A read then returns 0x88, and irq_o is 3'b000.
- R2: Bits 7 and 3 always read as 1, and writes to them have no effect.
- R3: Bits 6:4 are enable bits for channels 2:0. A write stores wdata_i[6:4], and a read returns the stored value.
- R4: A pulse on ovf_i[i] sets flag i (read bit i, for i = 0..2) on the next clock edge.
- R5: A pulse on unf_i[2] sets flag 2. Pulses on unf_i[1:0] have no effect.
- R6: A flag clears on a write with a 0 in its bit position, provided a read saw that flag as 1 and no write has occurred since that read.
- R7: A write of 0 to a flag that is not armed leaves the flag set. A write of 1 to a flag bit never changes the flag.
- R8: Every write clears all arms, whatever data it carries. A read that sees a flag as 0 does not arm that flag.
- R9: If a set pulse and a valid clearing write reach the same flag in the same cycle, the flag stays 1.
- R10: irq_o[i] is 1 exactly when flag i and enable i are both 1.
- R11: rdata_o is loaded one edge after a read cycle (cs_i=1, we_i=0) with the register value before that edge. It holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Register select |
| we_i | input | 1 | 1 = write, 0 = read (while cs_i=1) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ovf_i | input | 3 | Per-channel overflow pulses |
| unf_i | input | 3 | Per-channel underflow pulses (only bit 2 used) |
| irq_o | output | 3 | Per-channel interrupt requests |

## Verification
The bench tests the following corner cases:

- **Write 0 without a read.** A design that cleared on any 0 write would drop the flag.
- **Read that sees 0, then a new set, then a write 0.** A design that armed on every read would clear a flag that software never saw set.
- **Two writes after one read.** A design that kept the arm after a write would let the second write clear the flag.
- **Set pulse in the same cycle as a valid clear.** If the clear won, an overflow would be lost without trace.
- **Underflow pulses on channels 0 and 1.** A design that did not mask them would set flags 0 or 1 falsely.
- **Writes of 1 to flag and reserved bits.** A design that stored those bits would show wrong read data and wrong interrupt levels.

// File: rtl/ovf_status_pkg.sv
package ovf_status_pkg;
  parameter int unsigned NCH      = 3;
  parameter int unsigned DW       = 8;
  parameter int unsigned EN_LSB   = 4;
  parameter int unsigned FLAG_LSB = 0;
  parameter logic [NCH-1:0] UNF_MASK = 3'b100;
endpackage

// File: rtl/ovf_flag_bit.sv
module ovf_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, armed_q;
  logic clr;

  assign clr = wr_i && armed_q && !wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_i)    flag_q <= 1'b1;   // set beats clear
      else if (clr) flag_q <= 1'b0;
      if (wr_i)                armed_q <= 1'b0;
      else if (rd_i && flag_q) armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  a_r6_clear_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(armed_q && wr_i && !wbit_i));
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  a_r8_write_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !armed_q);
  a_r8_no_arm_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !flag_q && !armed_q) |=> !armed_q);
endmodule

// File: rtl/ovf_enable_reg.sv
module ovf_enable_reg #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] en_o
);
  logic [NCH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  a_r3_enable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_q));
endmodule

// File: rtl/ovf_rdata_reg.sv
module ovf_rdata_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= val_i;
  end

  assign rdata_o = rdata_q;

  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg
  import ovf_status_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NCH-1:0] ovf_i,
  input  logic [NCH-1:0] unf_i,
  output logic [NCH-1:0] irq_o
);
  logic           rd, wr;
  logic [NCH-1:0] set_vec, flags, en;
  logic [DW-1:0]  reg_val;

  assign rd      = cs_i && !we_i;
  assign wr      = cs_i && we_i;
  assign set_vec = ovf_i | (unf_i & UNF_MASK);

  for (genvar i = 0; i < NCH; i++) begin : g_flag
    ovf_flag_bit u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .rd_i   (rd),
      .wr_i   (wr),
      .wbit_i (wdata_i[FLAG_LSB+i]),
      .flag_o (flags[i])
    );
  end

  ovf_enable_reg #(.NCH(NCH)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .wdata_i (wdata_i[EN_LSB +: NCH]),
    .en_o    (en)
  );

  always_comb begin
    reg_val = '1;   // reserved bits read 1
    reg_val[FLAG_LSB +: NCH] = flags;
    reg_val[EN_LSB +: NCH]   = en;
  end

  ovf_rdata_reg #(.DW(DW)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd),
    .val_i   (reg_val),
    .rdata_o (rdata_o)
  );

  assign irq_o = flags & en;

  a_r2_reserved_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> (rdata_o[7] && rdata_o[3]));
  a_r4_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i[0] |=> irq_o[0] == en[0]);
  a_r5_unf_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_i[0] && !ovf_i[0] && !flags[0]) |=> !flags[0]);
  a_r10_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[2]) |-> ($rose(flags[2]) || $rose(en[2])));
endmodule

// File: tb/ovf_status_reg_bench.sv
module ovf_status_reg_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cs = 0, we = 0;
  logic [7:0] wd = 0;
  logic [2:0] ovf = 0, unf = 0;
  logic [7:0] rdata;
  logic [2:0] irq;

  int n_chk = 0, n_fail = 0;
  int m_flag = 0, m_en = 0, m_arm = 0, m_rd = 0;

  always #4 clk = ~clk;

  ovf_status_reg u_ovf_status_reg (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .wdata_i(wd),
    .rdata_o(rdata), .ovf_i(ovf), .unf_i(unf), .irq_o(irq)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; model updated from pre-edge state, compared after edge
  task automatic cyc(string tag, bit c, bit w, int d, int o, int u);
    int nf;
    @(negedge clk);
    cs = c; we = w; wd = d[7:0]; ovf = o[2:0]; unf = u[2:0];
    @(posedge clk);
    nf = m_flag;
    if (c && w) begin
      for (int i = 0; i < 3; i++)
        if (m_arm[i] && !d[i]) nf = nf & ~(1 << i);
      m_arm = 0;
      m_en  = (d >> 4) & 7;
    end else if (c) begin
      m_rd  = 8'h88 | (m_en << 4) | m_flag;
      m_arm = m_arm | m_flag;
    end
    nf = nf | o | (u & 4);
    m_flag = nf & 7;
    #2;
    check({tag, " rdata R11"}, int'(rdata), m_rd);
    check({tag, " irq R10"}, int'(irq), m_flag & m_en);
  endtask

  task automatic rd_chk(string tag, int exp);
    cyc(tag, 1, 0, 0, 0, 0);
    check(tag, int'(rdata), exp);
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd_chk("R1 reset", 8'h88);
    check("R1 irq", int'(irq), 0);
    cyc("R2", 1, 1, 8'hFF, 0, 0);           // reserved and flag writes of 1
    rd_chk("R2 R3 R7 write ones", 8'hF8);
    cyc("R3", 1, 1, 8'h50, 0, 0);
    rd_chk("R3 enable", 8'hD8);
    cyc("R4", 0, 0, 0, 3'b011, 0);
    rd_chk("R4 ovf", 8'hDB);
    cyc("R5", 0, 0, 0, 0, 3'b011);
    rd_chk("R5 unf masked", 8'hDB);
    cyc("R5", 0, 0, 0, 0, 3'b100);
    rd_chk("R5 unf ch2", 8'hDF);
    cyc("R6", 1, 1, 8'h50, 0, 0);           // armed by read above: clears all
    rd_chk("R6 clear", 8'hD8);
    cyc("R7", 0, 0, 0, 3'b001, 0);
    cyc("R7", 1, 1, 8'h50, 0, 0);           // no read before
    rd_chk("R7 unarmed zero", 8'hD9);
    cyc("R8", 1, 1, 8'h51, 0, 0);           // consumes arm, writes 1 to flag0
    cyc("R8", 1, 1, 8'h50, 0, 0);
    rd_chk("R8 disarmed", 8'hD9);
    cyc("R8", 1, 1, 8'h50, 0, 0);           // clears flag0 (armed)
    rd_chk("R8 clear", 8'hD8);              // read with flag1 at 0
    cyc("R8", 0, 0, 0, 3'b010, 0);
    cyc("R8", 1, 1, 8'h70, 0, 0);
    rd_chk("R8 zero read no arm", 8'hFA);
    cyc("R9", 1, 1, 8'h70, 3'b010, 0);      // armed clear + set same cycle
    rd_chk("R9 set wins", 8'hFA);
    cyc("R6", 1, 1, 8'h70, 0, 0);
    rd_chk("R6 clear after", 8'hF8);
    for (int k = 0; k < 200; k++) begin
      int r = (k * 37 + 11) % 97;
      cyc("R10 mix", r[0], r[1], (r * 29) & 8'hFF, r % 8, (r >> 2) % 8);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule